// File: doc/BRIEF.md
# Multicycle 16-bit Instruction Sequencer

This block is a small processor core that runs 16-bit instructions one phase at a time. A controller steps through fetch, decode, address evaluation, operand read, execute and store. Each phase is one register transfer through a memory address register, a memory data register and an instruction register. The core holds a program counter and eight general registers of 16 bits. It drives a synchronous single-port word memory through an address bus, a read strobe, a write strobe, a write-data bus and a read-data bus.

Two operations are implemented: a three-register add, and a load from memory at a base register plus a signed 6-bit offset. Any other opcode is decoded and then dropped, and fetch resumes at the next word. Each instruction passes only through the phases it needs, so it has a fixed cycle count. The memory port is a plain strobe interface with no back-pressure. A read strobe in one cycle must return its word on the read-data bus in the next cycle. Writes are never issued.

Top module: `seq16_core`

## Requirements
- R1: With `rst` high, no read is issued and `mem_addr` is 0. The first read after `rst` falls happens in the second cycle after release, at address 0. All eight general registers start at zero.
- R2: Every instruction fetch reads at the current program counter, which then advances by one. Instructions are therefore fetched from consecutive addresses 0, 1, 2, ...
- R3: A word returned on `mem_rdata` in the cycle after a read strobe is captured by the core. Data loaded from memory shows up correctly when it is used later as a base address.
- R4: Opcode `0001` (add) writes the sum of the registers named by bits [8:6] and [2:0], modulo 2^16, to the register named by bits [11:9]. It issues no operand read. Its fetch read and the next fetch read are 7 cycles apart.
- R5: Opcode `0110` (load) issues exactly one operand read, 5 cycles after its own fetch read, at the register named by bits [8:6] plus the offset in bits [5:0]. It writes the returned word to the register named by bits [11:9]. Its fetch read and the next fetch read are 9 cycles apart.
- R6: The load offset is sign-extended from bit 5, so that 6'b100000 is -32 and 6'b011111 is +31. The effective address wraps modulo 2^16.
- R7: Any opcode other than `0001` and `0110` changes no register and issues no operand read. Its fetch read and the next fetch read are 5 cycles apart.
- R8: `mem_wr` is never asserted.
- R9: The destination may equal a source, in which case the old source values are used. Register 0 is an ordinary writable register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Word address, taken from the memory address register |
| mem_rd | output | 1 | Read strobe; data is expected on `mem_rdata` one cycle later |
| mem_wr | output | 1 | Write strobe (held low) |
| mem_wdata | output | 16 | Write data (the memory data register) |
| mem_rdata | input | 16 | Read data from the memory |

## Verification
The hardest state to reach from the ports is the register file itself: no port exposes it. The stimulus program therefore follows every register write with a load that uses that register as its base. The register's value then appears on `mem_addr` during the operand read. The same trick covers the remaining cases. Sums that wrap, negative and extreme offsets, and addresses that wrap past 0xFFFF all show up as exact operand addresses. Unknown opcodes are followed by reads through the registers they could have corrupted. A reset in the middle of the program is followed by a load through register 0, which proves the registers were cleared.

// File: rtl/seq16_pkg.sv
package seq16_pkg;

  typedef enum logic [3:0] {
    S_F_MAR,   // address register takes program counter
    S_F_RD,    // instruction read strobe, counter advances
    S_F_MDR,   // data register captures instruction word
    S_F_IR,    // instruction register takes data register
    S_DEC,     // opcode decision
    S_EVA,     // effective address into address register
    S_OP_RD,   // operand read strobe
    S_OP_MDR,  // data register captures operand
    S_EXE,     // adder result captured
    S_STO      // destination register written
  } state_e;

  localparam logic [3:0] OPC_ADD = 4'b0001;
  localparam logic [3:0] OPC_LDR = 4'b0110;

endpackage

// File: rtl/seq16_regfile.sv
module seq16_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);

  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];

endmodule

// File: rtl/seq16_alu.sv
module seq16_alu #(
  parameter int DW   = 16,
  parameter int OFFW = 6
) (
  input  logic [DW-1:0]   opa,
  input  logic [DW-1:0]   opb,
  input  logic [OFFW-1:0] off,
  output logic [DW-1:0]   sum,
  output logic [DW-1:0]   ea
);

  logic [DW-1:0] off_ext;

  generate
    if (OFFW < DW) begin : g_sext
      assign off_ext = {{(DW-OFFW){off[OFFW-1]}}, off};
    end else begin : g_full
      assign off_ext = off[DW-1:0];
    end
  endgenerate

  assign sum = opa + opb;
  assign ea  = opa + off_ext;

endmodule

// File: rtl/seq16_ctrl.sv
module seq16_ctrl
  import seq16_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] opcode,
  output state_e     state,
  output logic       ld_mar_pc,
  output logic       ld_mar_ea,
  output logic       mem_rd,
  output logic       inc_pc,
  output logic       ld_mdr,
  output logic       ld_ir,
  output logic       ld_alu,
  output logic       rf_we,
  output logic       wsel_mdr
);

  state_e nxt;

  always_ff @(posedge clk) begin
    if (rst) state <= S_F_MAR;
    else     state <= nxt;
  end

  always_comb begin
    nxt = state;
    unique case (state)
      S_F_MAR:  nxt = S_F_RD;
      S_F_RD:   nxt = S_F_MDR;
      S_F_MDR:  nxt = S_F_IR;
      S_F_IR:   nxt = S_DEC;
      S_DEC: begin
        if (opcode == OPC_ADD)      nxt = S_EXE;
        else if (opcode == OPC_LDR) nxt = S_EVA;
        else                        nxt = S_F_MAR;
      end
      S_EVA:    nxt = S_OP_RD;
      S_OP_RD:  nxt = S_OP_MDR;
      S_OP_MDR: nxt = S_STO;
      S_EXE:    nxt = S_STO;
      S_STO:    nxt = S_F_MAR;
      default:  nxt = S_F_MAR;
    endcase
  end

  assign ld_mar_pc = (state == S_F_MAR);
  assign ld_mar_ea = (state == S_EVA);
  assign mem_rd    = (state == S_F_RD) || (state == S_OP_RD);
  assign inc_pc    = (state == S_F_RD);
  assign ld_mdr    = (state == S_F_MDR) || (state == S_OP_MDR);
  assign ld_ir     = (state == S_F_IR);
  assign ld_alu    = (state == S_EXE);
  assign rf_we     = (state == S_STO);
  assign wsel_mdr  = (opcode == OPC_LDR);

  // the add path enters execute straight from decode
  assert_add_path_R4: assert property (@(posedge clk) disable iff (rst)
    (state == S_EXE) |-> ($past(state) == S_DEC && opcode == OPC_ADD));

  // the operand read of a load follows address evaluation
  assert_ldr_order_R5: assert property (@(posedge clk) disable iff (rst)
    (state == S_OP_RD) |-> ($past(state) == S_EVA));

  // an unknown opcode goes back to fetch right after decode
  assert_nop_return_R7: assert property (@(posedge clk) disable iff (rst)
    (state == S_DEC && opcode != OPC_ADD && opcode != OPC_LDR) |=> (state == S_F_MAR));

endmodule

// File: rtl/seq16_core.sv
module seq16_core
  import seq16_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 8,
  parameter int OFFW = 6
) (
  input  logic          clk,
  input  logic          rst,
  output logic [DW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);

  localparam int AW      = $clog2(NREG);
  localparam int OPC_LSB = DW - 4;
  localparam int DST_LSB = 9;
  localparam int SA_LSB  = 6;
  localparam int SB_LSB  = 0;

  logic [DW-1:0] pc, ir, mar, mdr, alu_q;
  logic [DW-1:0] rd_a, rd_b, sum, ea, wdata;
  state_e        state;
  logic          ld_mar_pc, ld_mar_ea, inc_pc, ld_mdr, ld_ir, ld_alu, rf_we, wsel_mdr;
  logic [3:0]    opcode;

  assign opcode = ir[OPC_LSB +: 4];

  seq16_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .opcode    (opcode),
    .state     (state),
    .ld_mar_pc (ld_mar_pc),
    .ld_mar_ea (ld_mar_ea),
    .mem_rd    (mem_rd),
    .inc_pc    (inc_pc),
    .ld_mdr    (ld_mdr),
    .ld_ir     (ld_ir),
    .ld_alu    (ld_alu),
    .rf_we     (rf_we),
    .wsel_mdr  (wsel_mdr)
  );

  seq16_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (rf_we),
    .waddr   (ir[DST_LSB +: AW]),
    .wdata   (wdata),
    .raddr_a (ir[SA_LSB +: AW]),
    .raddr_b (ir[SB_LSB +: AW]),
    .rdata_a (rd_a),
    .rdata_b (rd_b)
  );

  seq16_alu #(.DW(DW), .OFFW(OFFW)) u_alu (
    .opa (rd_a),
    .opb (rd_b),
    .off (ir[OFFW-1:0]),
    .sum (sum),
    .ea  (ea)
  );

  assign wdata = wsel_mdr ? mdr : alu_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      ir    <= '0;
      mar   <= '0;
      mdr   <= '0;
      alu_q <= '0;
    end else begin
      if (ld_mar_pc)      mar <= pc;
      else if (ld_mar_ea) mar <= ea;
      if (inc_pc) pc    <= pc + 1'b1;
      if (ld_mdr) mdr   <= mem_rdata;
      if (ld_ir)  ir    <= mdr;
      if (ld_alu) alu_q <= sum;
    end
  end

  assign mem_addr  = mar;
  assign mem_wr    = 1'b0;
  assign mem_wdata = mdr;

  // an instruction read goes out at the program counter
  assert_fetch_addr_R2: assert property (@(posedge clk) disable iff (rst)
    (state == S_F_RD) |-> (mem_addr == pc));

  // the instruction register takes what the data register held
  assert_ir_from_mdr_R3: assert property (@(posedge clk) disable iff (rst)
    (state == S_F_IR) |=> (ir == $past(mdr)));

endmodule

// File: tb/seq16_core_tb.sv
module seq16_core_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_rd, mem_wr;

  always #5 clk = ~clk;

  seq16_core u_dut (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  // {instr, cycles to next fetch, has operand read, operand address, requirement}
  localparam int NV = 21;
  localparam logic [40:0] VEC [NV] = '{
    {16'h6218, 4'd9, 1'b1, 16'h0018, 4'd1},  // R1 = mem[0x18]; base R0 is zero
    {16'h6440, 4'd9, 1'b1, 16'h0040, 4'd3},  // R2 = mem[R1]; R1 came from memory
    {16'h667E, 4'd9, 1'b1, 16'h003E, 4'd6},  // R3 = mem[R1-2]
    {16'h6819, 4'd9, 1'b1, 16'h0019, 4'd5},  // R4 = 0x7FFF
    {16'h6A1A, 4'd9, 1'b1, 16'h001A, 4'd5},  // R5 = 1
    {16'h1D05, 4'd7, 1'b0, 16'h0000, 4'd4},  // R6 = R4+R5 = 0x8000
    {16'h6F80, 4'd9, 1'b1, 16'h8000, 4'd4},  // shows R6
    {16'h1D86, 4'd7, 1'b0, 16'h0000, 4'd9},  // R6 = R6+R6 wraps to 0
    {16'h6F85, 4'd9, 1'b1, 16'h0005, 4'd9},  // shows R6 = 0
    {16'hF23F, 4'd5, 1'b0, 16'h0000, 4'd7},  // unknown opcode
    {16'h5240, 4'd5, 1'b0, 16'h0000, 4'd7},  // unknown opcode
    {16'h0000, 4'd5, 1'b0, 16'h0000, 4'd7},  // unknown opcode
    {16'h6440, 4'd9, 1'b1, 16'h0040, 4'd7},  // R1 untouched by the above
    {16'h6660, 4'd9, 1'b1, 16'h0020, 4'd6},  // offset -32
    {16'h601B, 4'd9, 1'b1, 16'h001B, 4'd5},  // R0 = 2
    {16'h681F, 4'd9, 1'b1, 16'h0021, 4'd9},  // offset +31 on written R0
    {16'h6A3D, 4'd9, 1'b1, 16'hFFFF, 4'd6},  // 2-3 wraps; R5 = 0xBEEF
    {16'h1D42, 4'd7, 1'b0, 16'h0000, 4'd4},  // R6 = R5+R2 = 0xD123
    {16'h6F80, 4'd9, 1'b1, 16'hD123, 4'd4},  // shows R6
    {16'h1B40, 4'd7, 1'b0, 16'h0000, 4'd9},  // R5 = R5+R0 = 0xBEF1
    {16'h6F40, 4'd9, 1'b1, 16'hBEF1, 4'd9}   // shows R5
  };

  logic [15:0] mem [256];

  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];

  int          cyc = 0;
  int          logn = 0;
  logic [15:0] log_a [128];
  int          log_c [128];
  logic        wr_seen = 1'b0;
  logic        rd_in_rst = 1'b0;
  logic        addr_bad_rst = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      cyc  = 0;
      logn = 0;
      if (mem_rd === 1'b1) rd_in_rst = 1'b1;
      if (mem_addr !== 16'h0000 && $time > 10) addr_bad_rst = 1'b1;
    end else begin
      cyc++;
      if (mem_rd === 1'b1 && logn < 128) begin
        log_a[logn] = mem_addr;
        log_c[logn] = cyc;
        logn++;
      end
    end
    if (mem_wr !== 1'b0) wr_seen = 1'b1;
  end

  int n_chk = 0;
  int n_bad = 0;

  function automatic string tag(input int n);
    case (n)
      1: return "R1";  2: return "R2";  3: return "R3";
      4: return "R4";  5: return "R5";  6: return "R6";
      7: return "R7";  8: return "R8";  default: return "R9";
    endcase
  endfunction

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    for (int i = 0; i < NV; i++) mem[i] = VEC[i][40:25];
    mem[8'h18] = 16'h0040;
    mem[8'h19] = 16'h7FFF;
    mem[8'h1A] = 16'h0001;
    mem[8'h1B] = 16'h0002;
    mem[8'h3E] = 16'hA5A5;
    mem[8'h40] = 16'h1234;
    mem[8'hFF] = 16'hBEEF;

    // reset state
    repeat (4) @(negedge clk);
    #1;
    chk(rd_in_rst == 1'b0, "R1", "read during reset", 32'(rd_in_rst), 0);
    chk(mem_addr == 16'h0000, "R1", "address in reset", 32'(mem_addr), 0);
    rst = 1'b0;
    repeat (230) @(negedge clk);
    #2;

    // walk the program table
    begin
      int p = 0;
      for (int i = 0; i < NV; i++) begin
        logic [15:0] ins;
        int t;
        string ct;
        ins = VEC[i][40:25];
        ct  = (ins[15:12] == 4'b0001) ? "R4" : (ins[15:12] == 4'b0110) ? "R5" : "R7";
        if (i == 0) chk(log_c[0] == 1, "R1", "first fetch cycle", 32'(log_c[0]), 1);
        chk(log_a[p] == 16'(i), "R2", "fetch address", 32'(log_a[p]), 32'(i));
        t = log_c[p];
        if (VEC[i][20]) begin
          chk(log_c[p+1] == t + 5, "R5", "operand read cycle", 32'(log_c[p+1] - t), 5);
          chk(log_a[p+1] == VEC[i][19:4], tag(int'(VEC[i][3:0])), "operand address",
              32'(log_a[p+1]), 32'(VEC[i][19:4]));
          p += 2;
        end else begin
          p += 1;
        end
        chk(log_c[p] - t == int'(VEC[i][24:21]), ct, "fetch spacing",
            32'(log_c[p] - t), 32'(VEC[i][24:21]));
      end
    end

    // reset in mid-run: registers cleared, fetch restarts at 0
    @(negedge clk);
    #1 rst = 1'b1;
    rd_in_rst = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(rd_in_rst == 1'b0, "R1", "read during second reset", 32'(rd_in_rst), 0);
    chk(mem_addr == 16'h0000, "R1", "address after second reset", 32'(mem_addr), 0);
    rst = 1'b0;
    repeat (12) @(negedge clk);
    #2;
    chk(log_c[0] == 1 && log_a[0] == 16'h0000, "R1", "restart fetch", 32'(log_a[0]), 0);
    chk(log_c[1] == 6 && log_a[1] == 16'h0018, "R1", "R0 cleared by reset", 32'(log_a[1]), 32'h18);
    chk(log_c[2] == 10 && log_a[2] == 16'h0001, "R2", "second fetch", 32'(log_a[2]), 1);
    chk(wr_seen == 1'b0, "R8", "write strobe seen", 32'(wr_seen), 0);
    chk(addr_bad_rst == 1'b0, "R1", "address held at 0 in reset", 32'(addr_bad_rst), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule